// File: doc/BRIEF.md
# Paired Byte Queues with Fill-Level Interrupt Identification

This block keeps the receive and transmit byte queues of a 16550-style serial controller and derives the interrupt identification nibble from how full they are. The line side pushes received bytes into the receive queue, and the host pops them. The host pushes bytes into the transmit queue, and the shifter pops them. Each queue has its own count, full and empty flags. The oldest byte is always visible on the read-data output.

A FIFO-control write picks the receive threshold (1, 4, 8 or 14 bytes). The same write can flush the receive queue, the transmit queue or both. Two interrupt enables select which conditions may claim the identification field:
- The receive threshold condition.
- The transmit "room available" condition.

The receive threshold condition wins over the transmit condition. The interrupt request mirrors the pending state of the nibble.

Top module: `uart_qpair`

## Requirements
- R1: After reset both queues are empty with count 0, the receive threshold is 14 and `iir_nib` reads 4'b0001 with `irq` low.
- R2: Each queue holds 16 bytes in arrival order. `*_rdata` shows the oldest byte, `*_count` gives the fill level, and `*_full` is high exactly when the count is 16.
- R3: A push into a full queue without a pop in the same cycle discards the byte and keeps the count at 16. For the receive queue, `rx_overrun` is high for the single cycle after that push. For the transmit queue, `tx_discard` behaves the same way.
- R4: A push and a pop on the same non-empty queue in one cycle leave the count unchanged and raise no overrun, even when the queue is full.
- R5: A pop from an empty queue returns nothing and changes no count or flag.
- R6: A FIFO-control write with `fcr_enable`=1 loads the threshold from `fcr_trig`. `fcr_rx_clr` empties only the receive queue and `fcr_tx_clr` empties only the transmit queue.
- R7: A FIFO-control write with `fcr_enable`=0 empties both queues and leaves the threshold unchanged.
- R8: `fcr_trig` codes 00, 01, 10 and 11 select thresholds of 1, 4, 8 and 14 bytes. With `ier_en[0]` set, a receive count at or above the threshold makes `iir_nib` read 4'b0100 one cycle after the count reaches it.
- R9: While the code is 2, a receive count below the threshold returns the nibble to 4'b0001 on the next cycle, unless the transmit condition of R10 claims it in the same cycle.
- R10: With `ier_en[1]` set and the transmit queue not full, `iir_nib` becomes 4'b0010 on the next cycle. While the code is 1, a full transmit queue returns it to 4'b0001.
- R11: When the receive condition of R8 and the transmit condition of R10 hold in the same cycle, the code becomes 2.
- R12: `irq` is high exactly when `iir_nib[0]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Push `rx_wdata` into the receive queue |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Remove the oldest receive byte |
| rx_rdata | output | 8 | Oldest receive byte (0 when empty) |
| rx_count | output | 5 | Receive fill level |
| rx_full | output | 1 | Receive queue holds 16 bytes |
| rx_empty | output | 1 | Receive queue holds nothing |
| rx_overrun | output | 1 | One-cycle pulse after a discarded receive push |
| tx_push | input | 1 | Push `tx_wdata` into the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Remove the oldest transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte (0 when empty) |
| tx_count | output | 5 | Transmit fill level |
| tx_full | output | 1 | Transmit queue holds 16 bytes |
| tx_empty | output | 1 | Transmit queue holds nothing |
| tx_discard | output | 1 | One-cycle pulse after a discarded transmit push |
| fcr_wr | input | 1 | FIFO-control write strobe |
| fcr_enable | input | 1 | FIFO enable field of the write |
| fcr_rx_clr | input | 1 | Flush receive queue (when enabled) |
| fcr_tx_clr | input | 1 | Flush transmit queue (when enabled) |
| fcr_trig | input | 2 | Receive threshold select |
| ier_en | input | 2 | Bit 0 receive-threshold enable, bit 1 transmit-room enable |
| iir_nib | output | 4 | Bit 0 not-pending, bits 3:1 identification code |
| irq | output | 1 | Interrupt request |

## Verification
Counts, flags and read data change at the clock edge that takes a push, pop or flush, so they are compared at the falling edge right after that edge. The identification nibble and `irq` are registered from those counts, so they trail by one more cycle. The bench waits one extra cycle before every nibble check and checks the previous value just before the threshold is crossed. The overrun and discard pulses are checked on the cycle after the offending push and again one cycle later to confirm they have dropped. A scoreboard queue holds every byte the bench expects the design to accept. Popped bytes are compared against it between edges, while the pop strobe is still applied.

// File: rtl/uart_qpair_pkg.sv
package uart_qpair_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        IID_NONE = 3'd0,
        IID_TXE  = 3'd1,
        IID_RXT  = 3'd2
    } iid_e;

    // Packed so that code lands in bits 3:1 and idle (not-pending) in bit 0
    typedef struct packed {
        iid_e code;
        logic idle;
    } ident_t;

    localparam ident_t IDENT_IDLE = '{code: IID_NONE, idle: 1'b1};
    localparam logic [1:0] TRIG_RST = 2'b11;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_byte_queue.sv
module uart_byte_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          drop
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = !full_q && (wp == rp);
    assign full    = full_q;
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full_q || do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp     <= '0;
            rp     <= '0;
            full_q <= 1'b0;
            drop   <= 1'b0;
        end else begin
            drop <= push && full_q && !pop;
            if (flush) begin
                wp     <= '0;
                rp     <= '0;
                full_q <= 1'b0;
            end else begin
                if (do_push) wp <= bump(wp);
                if (do_pop)  rp <= bump(rp);
                if (do_push && !do_pop && (bump(wp) == rp))
                    full_q <= 1'b1;
                else if (do_pop && !do_push)
                    full_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wp] <= wdata;
    end

    always_comb begin
        if (full_q)
            count = CW'(DEPTH);
        else if (wp >= rp)
            count = CW'(wp - rp);
        else
            count = CW'(DEPTH) - CW'(rp) + CW'(wp);
    end

    assign rdata = empty ? '0 : mem[rp];

endmodule

// File: rtl/uart_iir_gen.sv
module uart_iir_gen
    import uart_qpair_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] rx_count,
    input  logic          tx_full,
    input  logic [1:0]    trig_sel,
    input  logic          en_rx,
    input  logic          en_tx,
    output ident_t        ident
);

    ident_t cur, nxt;
    logic   rx_hit;

    always_comb begin
        rx_hit = 32'(rx_count) >= trig_level(trig_sel);
        nxt    = cur;
        if (en_rx && rx_hit) begin
            nxt = '{code: IID_RXT, idle: 1'b0};
        end else begin
            if (nxt.code == IID_RXT && !rx_hit)
                nxt = IDENT_IDLE;
            if (nxt.code == IID_TXE && tx_full)
                nxt = IDENT_IDLE;
            else if (en_tx && !tx_full)
                nxt = '{code: IID_TXE, idle: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= IDENT_IDLE;
        else     cur <= nxt;
    end

    assign ident = cur;

endmodule

// File: rtl/uart_qpair.sv
module uart_qpair
    import uart_qpair_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_rdata,
    output logic [CW-1:0]     rx_count,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_overrun,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_rdata,
    output logic [CW-1:0]     tx_count,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_discard,
    input  logic              fcr_wr,
    input  logic              fcr_enable,
    input  logic              fcr_rx_clr,
    input  logic              fcr_tx_clr,
    input  logic [1:0]        fcr_trig,
    input  logic [1:0]        ier_en,
    output logic [3:0]        iir_nib,
    output logic              irq
);

    logic [1:0] trig_q;
    logic       rx_flush, tx_flush;
    ident_t     ident;

    assign rx_flush = fcr_wr && (!fcr_enable || fcr_rx_clr);
    assign tx_flush = fcr_wr && (!fcr_enable || fcr_tx_clr);

    always_ff @(posedge clk) begin
        if (rst)                      trig_q <= TRIG_RST;
        else if (fcr_wr && fcr_enable) trig_q <= fcr_trig;
    end

    uart_byte_queue #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
        .rdata(rx_rdata), .count(rx_count),
        .full(rx_full), .empty(rx_empty), .drop(rx_overrun)
    );

    uart_byte_queue #(.DEPTH(DEPTH), .W(BYTE_W)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
        .rdata(tx_rdata), .count(tx_count),
        .full(tx_full), .empty(tx_empty), .drop(tx_discard)
    );

    uart_iir_gen #(.CW(CW)) u_iir (
        .clk(clk), .rst(rst),
        .rx_count(rx_count), .tx_full(tx_full), .trig_sel(trig_q),
        .en_rx(ier_en[0]), .en_tx(ier_en[1]),
        .ident(ident)
    );

    assign iir_nib = ident;
    assign irq     = !ident.idle;

endmodule

// File: rtl/uart_qpair_chk.sv
module uart_qpair_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          rx_full,
    input logic          rx_empty,
    input logic [CW-1:0] rx_count,
    input logic          rx_overrun,
    input logic          tx_full,
    input logic          tx_empty,
    input logic          fcr_wr,
    input logic          fcr_enable,
    input logic [3:0]    iir_nib
);

    a_r2_full_count: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> rx_count == CW'(DEPTH));

    a_r3_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |-> $past(rx_full && rx_push && !rx_pop));

    a_r3_stays_full: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rx_push && !rx_pop && !fcr_wr) |=> rx_full);

    a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (rx_empty && rx_pop && !rx_push) |=> rx_empty);

    a_r7_flush_both: assert property (@(posedge clk) disable iff (rst)
        (fcr_wr && !fcr_enable) |=> (rx_empty && tx_empty));

    a_r8_rxt_pending: assert property (@(posedge clk) disable iff (rst)
        (iir_nib[3:1] == 3'd2) |-> !iir_nib[0]);

    a_r8_code_legal: assert property (@(posedge clk) disable iff (rst)
        iir_nib[3:1] <= 3'd2);

    a_r10_txe_room: assert property (@(posedge clk) disable iff (rst)
        (iir_nib[3:1] == 3'd1) |-> $past(!tx_full));

endmodule

bind uart_qpair uart_qpair_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full),
    .rx_empty(rx_empty), .rx_count(rx_count), .rx_overrun(rx_overrun),
    .tx_full(tx_full), .tx_empty(tx_empty),
    .fcr_wr(fcr_wr), .fcr_enable(fcr_enable), .iir_nib(iir_nib)
);

// File: tb/uart_qpair_test.sv
`timescale 1ns/1ps
module uart_qpair_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
    logic [7:0] rx_wdata = 0, tx_wdata = 0;
    logic [7:0] rx_rdata, tx_rdata;
    logic [4:0] rx_count, tx_count;
    logic       rx_full, rx_empty, rx_overrun;
    logic       tx_full, tx_empty, tx_discard;
    logic       fcr_wr = 0, fcr_enable = 0, fcr_rx_clr = 0, fcr_tx_clr = 0;
    logic [1:0] fcr_trig = 0;
    logic [1:0] ier_en = 0;
    logic [3:0] iir_nib;
    logic       irq;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] rx_sb[$];
    logic [7:0] tx_sb[$];

    always #4 clk = ~clk;

    uart_qpair uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_wdata = b;
        rx_push  = 1;
        if (!rx_full || rx_pop) rx_sb.push_back(b);
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_wdata = b;
        tx_push  = 1;
        if (!tx_full || tx_pop) tx_sb.push_back(b);
        @(negedge clk);
        tx_push = 0;
    endtask

    task automatic pop_rx();
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    task automatic pop_tx();
        tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    // bits: 0 enable, 1 rx flush, 2 tx flush, 7:6 threshold select
    task automatic wr_fcr(input logic [7:0] v);
        fcr_enable = v[0];
        fcr_rx_clr = v[1];
        fcr_tx_clr = v[2];
        fcr_trig   = v[7:6];
        fcr_wr     = 1;
        if (!v[0] || v[1]) rx_sb.delete();
        if (!v[0] || v[2]) tx_sb.delete();
        @(negedge clk);
        fcr_wr = 0;
    endtask

    // Monitor: compare the head byte while the pop strobe is applied
    always begin
        @(negedge clk);
        #2;
        if (!rst && rx_pop && !rx_empty) begin
            if (rx_sb.size() == 0) chk("R2 rx unexpected byte", rx_rdata, 0);
            else chk("R2 rx order", rx_rdata, rx_sb.pop_front());
        end
        if (!rst && tx_pop && !tx_empty) begin
            if (tx_sb.size() == 0) chk("R2 tx unexpected byte", tx_rdata, 0);
            else chk("R2 tx order", tx_rdata, tx_sb.pop_front());
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 iir", iir_nib, 4'h1);
        chk("R12 irq idle", irq, 0);

        // R1 default threshold 14: three bytes raise nothing
        ier_en = 2'b01;
        push_rx(8'hA0); push_rx(8'hA1); push_rx(8'hA2);
        chk("R2 rx_count 3", rx_count, 3);
        tick();
        chk("R1 threshold 14 quiet", iir_nib, 4'h1);

        // R8 threshold 1
        wr_fcr(8'h01);
        tick();
        chk("R8 trig1 iir", iir_nib, 4'h4);
        chk("R12 irq raised", irq, 1);
        pop_rx(); pop_rx(); pop_rx();
        chk("R2 drained", rx_empty, 1);
        tick();
        chk("R9 clear below", iir_nib, 4'h1);

        // R8 threshold 4
        wr_fcr(8'h41);
        for (int i = 0; i < 3; i++) push_rx(8'h10 + 8'(i));
        tick();
        chk("R8 trig4 below", iir_nib, 4'h1);
        push_rx(8'h13);
        tick();
        chk("R8 trig4 at", iir_nib, 4'h4);
        wr_fcr(8'h43);
        chk("R6 rx flush", rx_count, 0);
        tick();
        chk("R9 clear after flush", iir_nib, 4'h1);

        // R8 threshold 8
        wr_fcr(8'h81);
        for (int i = 0; i < 7; i++) push_rx(8'h20 + 8'(i));
        tick();
        chk("R8 trig8 below", iir_nib, 4'h1);
        push_rx(8'h27);
        tick();
        chk("R8 trig8 at", iir_nib, 4'h4);
        wr_fcr(8'h83);

        // R8 threshold 14, then fill and overflow
        wr_fcr(8'hC1);
        for (int i = 0; i < 13; i++) push_rx(8'h30 + 8'(i));
        tick();
        chk("R8 trig14 below", iir_nib, 4'h1);
        push_rx(8'h3D);
        tick();
        chk("R8 trig14 at", iir_nib, 4'h4);
        push_rx(8'h3E); push_rx(8'h3F);
        chk("R2 full flag", rx_full, 1);
        chk("R2 full count", rx_count, 16);
        push_rx(8'hEE);
        chk("R3 overrun pulse", rx_overrun, 1);
        chk("R3 count held", rx_count, 16);
        tick();
        chk("R3 pulse one cycle", rx_overrun, 0);

        // R4 push and pop together on a full queue
        rx_pop = 1;
        push_rx(8'h55);
        rx_pop = 0;
        chk("R4 count unchanged", rx_count, 16);
        chk("R4 no overrun", rx_overrun, 0);

        // Drain (monitor checks order, 0x55 last) then pop empty
        for (int i = 0; i < 16; i++) pop_rx();
        chk("R2 rx sb drained", rx_sb.size(), 0);
        pop_rx();
        chk("R5 empty pop count", rx_count, 0);
        chk("R5 empty pop flag", rx_empty, 1);
        chk("R5 empty pop full", rx_full, 0);

        // R10 transmit room
        ier_en = 2'b10;
        tick();
        chk("R10 txe code", iir_nib, 4'h2);
        chk("R12 irq txe", irq, 1);
        for (int i = 0; i < 16; i++) push_tx(8'h60 + 8'(i));
        chk("R2 tx full", tx_full, 1);
        tick();
        chk("R10 clear when full", iir_nib, 4'h1);
        chk("R12 irq low", irq, 0);
        push_tx(8'hFF);
        chk("R3 tx discard", tx_discard, 1);
        chk("R3 tx count held", tx_count, 16);

        // R6 selective transmit flush
        push_rx(8'h71); push_rx(8'h72);
        wr_fcr(8'hC5);
        chk("R6 tx flushed", tx_count, 0);
        chk("R6 rx kept", rx_count, 2);

        // R11 priority
        ier_en = 2'b11;
        wr_fcr(8'h01);
        tick();
        chk("R11 rx wins", iir_nib, 4'h4);
        pop_rx(); pop_rx();
        for (int i = 0; i < 3; i++) push_tx(8'h80 + 8'(i));
        for (int i = 0; i < 3; i++) pop_tx();
        chk("R2 tx sb drained", tx_sb.size(), 0);

        // R7 disabled write flushes both, threshold kept at 1
        push_rx(8'h90);
        push_tx(8'h91);
        wr_fcr(8'h40);
        chk("R7 rx flushed", rx_count, 0);
        chk("R7 tx flushed", tx_count, 0);
        tick();
        chk("R9 rx cleared, R10 txe takes", iir_nib, 4'h2);
        push_rx(8'h92);
        tick();
        chk("R7 threshold kept", iir_nib, 4'h4);

        summary();
    end

endmodule